// File: doc/BRIEF.md
# Interrupt Vector Table Register File

This block holds the programmable side of a message-signalled interrupt table: a set of vector entries, each 16 bytes wide, and an array of pending bits. A host bus reads and writes the table through a byte offset, a transfer size of 4 or 8 bytes and a 64-bit data path. A delivery engine next to the block sees every entry's message address, message data and mask bit as flat output vectors. It raises or drops pending bits through per-vector set and clear inputs.

Within an entry, the dword at byte 0x0 is the low half of the message address, 0x4 the high half, 0x8 the message data and 0xC the vector control word. Only bit 0 of the control word, the per-vector mask, is stored. A qword access packs two neighbouring dwords, with the lower-offset dword in the lower half. The pending array has its own region, chosen by a select input. It can be read but not written. Each write cycle also gives the delivery engine two per-vector pulses: one when a vector is unmasked, and one when its address or data changes.

Top module: `msix_vec_regfile`

## Requirements
- R1: After reset every entry has its mask bit at 1 and its address and data at 0, and every pending bit is 0.
- R2: A 4-byte table access at byte offset `off` uses entry `off/16` and field `(off%16)/4`: 0 is address low, 1 is address high, 2 is data, 3 is control. Read data comes back in bits 31:0 with bits 63:32 zero, and `bus_rvalid` is high in the cycle after the request.
- R3: An 8-byte table access at entry offset 0x0 carries address high in bits 63:32 and address low in bits 31:0. At offset 0x8 it carries the control word in bits 63:32 and the data in bits 31:0.
- R4: Only bit 0 of the control word (the mask) is stored. A read returns the other 31 bits as zero.
- R5: A table access whose entry index is `NUM_VEC` or more is ignored. Its write changes nothing and raises no pulse, and its read returns zero.
- R6: An access with a size other than 4 or 8 is ignored, and so is one whose offset is not a multiple of its size, on either region. Reads of this kind return zero.
- R7: In the pending region, vector v sits in qword v/64 at bit v%64. A 4-byte read at qword offset 0x4 returns bits 63:32. Bits of vectors that do not exist, and qwords beyond the array, read as zero.
- R8: Bus writes to the pending region leave every pending bit unchanged.
- R9: `pend_set[v]` sets and `pend_clr[v]` clears pending bit v at the next clock edge. Set wins when both are high.
- R10: `unmask_stb[v]` is high for exactly the one cycle after a bus write that changes vector v's mask from 1 to 0.
- R11: `route_stb[v]` is high for exactly the one cycle after a bus write that changes vector v's address or data value. A write of an unchanged value raises no pulse.
- R12: `ent_addr`, `ent_data` and `ent_mask` show the stored contents of each entry, with entry v at slice v of each vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_pba | input | 1 | 1 = pending region, 0 = vector table |
| bus_off | input | OFF_W | Byte offset within the region |
| bus_size | input | 4 | Transfer size in bytes |
| bus_wdata | input | 64 | Write data, little-endian |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 64 | Read response data |
| pend_set | input | NUM_VEC | Per-vector pending set |
| pend_clr | input | NUM_VEC | Per-vector pending clear |
| pend_out | output | NUM_VEC | Pending bits |
| ent_addr | output | NUM_VEC*64 | Message address of each entry |
| ent_data | output | NUM_VEC*32 | Message data of each entry |
| ent_mask | output | NUM_VEC | Mask bit of each entry |
| unmask_stb | output | NUM_VEC | Mask 1-to-0 pulse per entry |
| route_stb | output | NUM_VEC | Address or data change pulse per entry |

## Verification
Random sequences mix dword and qword accesses, including bad sizes, misaligned offsets and indices past the last vector, so every read is compared with a bench model. A lane-swap or a field-decode mistake shows up as a data mismatch, and a missing range or alignment guard shows up as corrupted model state. Directed cases rewrite a field with the value it already holds, so the change pulses can be told apart from plain write-enable pulses. They also hit the second pending qword and its high dword, which separates correct v/64 and v%64 placement from an off-by-one. Bursts of pending set and clear, some with both on the same vector, check the priority between the two.

// File: rtl/msix_vec_regfile.sv
module msix_vec_regfile #(
  parameter int NUM_VEC = 70,
  parameter int OFF_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_req,
  input  logic                  bus_we,
  input  logic                  bus_pba,
  input  logic [OFF_W-1:0]      bus_off,
  input  logic [3:0]            bus_size,
  input  logic [63:0]           bus_wdata,
  output logic                  bus_rvalid,
  output logic [63:0]           bus_rdata,
  input  logic [NUM_VEC-1:0]    pend_set,
  input  logic [NUM_VEC-1:0]    pend_clr,
  output logic [NUM_VEC-1:0]    pend_out,
  output logic [NUM_VEC*64-1:0] ent_addr,
  output logic [NUM_VEC*32-1:0] ent_data,
  output logic [NUM_VEC-1:0]    ent_mask,
  output logic [NUM_VEC-1:0]    unmask_stb,
  output logic [NUM_VEC-1:0]    route_stb
);
  localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int PBA_QW = (NUM_VEC + 63) / 64;
  localparam int PQ_W   = (PBA_QW > 1) ? $clog2(PBA_QW) : 1;

  initial begin
    if (NUM_VEC < 1 || NUM_VEC > 2048) $error("NUM_VEC out of range");
    if (OFF_W - 4 < IDX_W + 1) $error("OFF_W too small for NUM_VEC");
  end

  logic [31:0] alo_q [NUM_VEC];
  logic [31:0] ahi_q [NUM_VEC];
  logic [31:0] dat_q [NUM_VEC];
  logic [NUM_VEC-1:0] msk_q;
  logic [NUM_VEC-1:0] pend_q;

  wire sz4 = (bus_size == 4'd4);
  wire sz8 = (bus_size == 4'd8);
  wire shape_ok = (sz4 && bus_off[1:0] == 2'b00) || (sz8 && bus_off[2:0] == 3'b000);

  wire [OFF_W-5:0] tbl_idx = bus_off[OFF_W-1:4];
  wire [1:0]       fld     = bus_off[3:2];
  wire             tbl_rng = int'(tbl_idx) < NUM_VEC;
  wire [OFF_W-4:0] pq      = bus_off[OFF_W-1:3];
  wire             pba_rng = int'(pq) < PBA_QW;

  wire tbl_ok = shape_ok && !bus_pba && tbl_rng;
  wire pba_ok = shape_ok && bus_pba && pba_rng;
  wire rd_ok  = tbl_ok || pba_ok;
  wire wr_tbl = bus_req && bus_we && tbl_ok;
  wire rd_req = bus_req && !bus_we;

  // entries
  for (genvar i = 0; i < NUM_VEC; i++) begin : g_ent
    wire hit = wr_tbl && (int'(tbl_idx) == i);
    logic [31:0] n_alo, n_ahi, n_dat;
    logic        n_msk;
    always_comb begin
      n_alo = alo_q[i];
      n_ahi = ahi_q[i];
      n_dat = dat_q[i];
      n_msk = msk_q[i];
      if (sz8) begin
        if (fld == 2'd0) begin
          n_alo = bus_wdata[31:0];
          n_ahi = bus_wdata[63:32];
        end else begin
          n_dat = bus_wdata[31:0];
          n_msk = bus_wdata[32];
        end
      end else begin
        case (fld)
          2'd0: n_alo = bus_wdata[31:0];
          2'd1: n_ahi = bus_wdata[31:0];
          2'd2: n_dat = bus_wdata[31:0];
          default: n_msk = bus_wdata[0];
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alo_q[i]      <= '0;
        ahi_q[i]      <= '0;
        dat_q[i]      <= '0;
        msk_q[i]      <= 1'b1;
        unmask_stb[i] <= 1'b0;
        route_stb[i]  <= 1'b0;
      end else begin
        unmask_stb[i] <= hit && msk_q[i] && !n_msk;
        route_stb[i]  <= hit && ({n_ahi, n_alo, n_dat} != {ahi_q[i], alo_q[i], dat_q[i]});
        if (hit) begin
          alo_q[i] <= n_alo;
          ahi_q[i] <= n_ahi;
          dat_q[i] <= n_dat;
          msk_q[i] <= n_msk;
        end
      end
    end

    assign ent_addr[i*64 +: 64] = {ahi_q[i], alo_q[i]};
    assign ent_data[i*32 +: 32] = dat_q[i];

    AST_UNMASK_FROM_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      unmask_stb[i] |-> (!msk_q[i] && $past(msk_q[i]))); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      pend_set[i] |=> pend_q[i]); // R9
  end

  assign ent_mask = msk_q;

  // pending array
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~pend_clr) | pend_set;
  end
  assign pend_out = pend_q;

  logic [PBA_QW*64-1:0] pend_pad;
  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_VEC-1:0] = pend_q;
  end

  // read path
  wire [IDX_W-1:0] ri = tbl_rng ? tbl_idx[IDX_W-1:0] : '0;
  wire [PQ_W-1:0]  pi = pba_rng ? pq[PQ_W-1:0] : '0;
  wire [63:0] pba_qw = 64'(pend_pad >> {pi, 6'b0});

  logic [63:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (bus_pba) begin
      if (sz8)               rd_val = pba_qw;
      else if (bus_off[2])   rd_val = {32'b0, pba_qw[63:32]};
      else                   rd_val = {32'b0, pba_qw[31:0]};
    end else if (sz8) begin
      rd_val = (fld == 2'd0) ? {ahi_q[ri], alo_q[ri]} : {31'b0, msk_q[ri], dat_q[ri]};
    end else begin
      case (fld)
        2'd0: rd_val = {32'b0, alo_q[ri]};
        2'd1: rd_val = {32'b0, ahi_q[ri]};
        2'd2: rd_val = {32'b0, dat_q[ri]};
        default: rd_val = {63'b0, msk_q[ri]};
      endcase
    end
    if (!rd_ok) rd_val = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_req;
      bus_rdata  <= rd_req ? rd_val : '0;
    end
  end

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid); // R2
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ok) |=> (bus_rdata == '0)); // R5
  AST_PBA_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_pba && pend_set == '0 && pend_clr == '0) |=> $stable(pend_out)); // R8
  AST_NO_STROBE_ON_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_req && bus_we && !bus_pba)) |=> (unmask_stb == '0 && route_stb == '0)); // R5
endmodule

// File: tb/msix_vec_regfile_bench.sv
`timescale 1ns/1ps
module msix_vec_regfile_bench;
  localparam int N = 70;
  localparam int OW = 16;
  localparam int PQ = (N + 63) / 64;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0, bus_pba = 0;
  logic [OW-1:0] bus_off = '0;
  logic [3:0] bus_size = '0;
  logic [63:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [63:0] bus_rdata;
  logic [N-1:0] pend_set = '0, pend_clr = '0, pend_out, ent_mask, unmask_stb, route_stb;
  logic [N*64-1:0] ent_addr;
  logic [N*32-1:0] ent_data;

  msix_vec_regfile #(.NUM_VEC(N), .OFF_W(OW)) u_msix_vec_regfile (
    .clk, .rst_n, .bus_req, .bus_we, .bus_pba, .bus_off, .bus_size, .bus_wdata,
    .bus_rvalid, .bus_rdata, .pend_set, .pend_clr, .pend_out,
    .ent_addr, .ent_data, .ent_mask, .unmask_stb, .route_stb);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic [31:0] m_alo [N];
  logic [31:0] m_ahi [N];
  logic [31:0] m_dat [N];
  logic [N-1:0] m_msk, m_pend;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit shape(int off, int size);
    return (size == 4 && off % 4 == 0) || (size == 8 && off % 8 == 0);
  endfunction

  function automatic logic [63:0] exp_rd(bit pba, int off, int size);
    logic [63:0] q = '0;
    if (!shape(off, size)) return '0;
    if (pba) begin
      if (off / 8 >= PQ) return '0;
      for (int b = 0; b < 64; b++)
        if ((off / 8) * 64 + b < N) q[b] = m_pend[(off / 8) * 64 + b];
      if (size == 8) return q;
      return (off % 8 == 4) ? {32'b0, q[63:32]} : {32'b0, q[31:0]};
    end
    if (off / 16 >= N) return '0;
    begin
      int i = off / 16;
      int f = (off % 16) / 4;
      if (size == 8) return (f == 0) ? {m_ahi[i], m_alo[i]} : {31'b0, m_msk[i], m_dat[i]};
      case (f)
        0: return {32'b0, m_alo[i]};
        1: return {32'b0, m_ahi[i]};
        2: return {32'b0, m_dat[i]};
        default: return {63'b0, m_msk[i]};
      endcase
    end
  endfunction

  task automatic do_wr(input bit pba, input int off, input int size, input logic [63:0] d, input string tag);
    logic [N-1:0] eu = '0, er = '0;
    if (!pba && shape(off, size) && off / 16 < N) begin
      int i = off / 16;
      int f = (off % 16) / 4;
      logic [95:0] old = {m_ahi[i], m_alo[i], m_dat[i]};
      logic om = m_msk[i];
      if (size == 8) begin
        if (f == 0) begin m_alo[i] = d[31:0]; m_ahi[i] = d[63:32]; end
        else begin m_dat[i] = d[31:0]; m_msk[i] = d[32]; end
      end else begin
        case (f)
          0: m_alo[i] = d[31:0];
          1: m_ahi[i] = d[31:0];
          2: m_dat[i] = d[31:0];
          default: m_msk[i] = d[0];
        endcase
      end
      eu[i] = om && !m_msk[i];
      er[i] = old != {m_ahi[i], m_alo[i], m_dat[i]};
    end
    bus_req = 1; bus_we = 1; bus_pba = pba; bus_off = OW'(off); bus_size = 4'(size); bus_wdata = d;
    @(negedge clk);
    chk(unmask_stb == eu, {tag, " R10 unmask pulse"}, 64'(unmask_stb), 64'(eu));
    chk(route_stb == er, {tag, " R11 route pulse"}, 64'(route_stb), 64'(er));
    bus_req = 0; bus_we = 0;
  endtask

  task automatic do_rd(input bit pba, input int off, input int size, input string tag);
    logic [63:0] e = exp_rd(pba, off, size);
    bus_req = 1; bus_we = 0; bus_pba = pba; bus_off = OW'(off); bus_size = 4'(size);
    @(negedge clk);
    chk(bus_rvalid === 1'b1, {tag, " R2 rvalid"}, 64'(bus_rvalid), 64'd1);
    chk(bus_rdata === e, tag, bus_rdata, e);
    bus_req = 0;
  endtask

  task automatic do_pend(input logic [N-1:0] s, input logic [N-1:0] c, input string tag);
    pend_set = s; pend_clr = c;
    @(negedge clk);
    m_pend = (m_pend & ~c) | s;
    pend_set = '0; pend_clr = '0;
    chk(pend_out == m_pend, tag, 64'(pend_out), 64'(m_pend));
  endtask

  task automatic chk_ents(input string tag);
    bit ok = 1;
    for (int i = 0; i < N; i++)
      if (ent_addr[i*64 +: 64] !== {m_ahi[i], m_alo[i]} || ent_data[i*32 +: 32] !== m_dat[i]) ok = 0;
    chk(ok && ent_mask == m_msk, tag, 64'(ent_mask), 64'(m_msk));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    for (int i = 0; i < N; i++) begin m_alo[i] = 0; m_ahi[i] = 0; m_dat[i] = 0; end
    m_msk = '1; m_pend = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_ents("R1 reset entries");
    chk(pend_out == '0, "R1 reset pending", 64'(pend_out), 0);
    do_rd(0, 16'h0C, 4, "R1 ctl after reset");
    do_rd(0, 16'h10 * 69 + 8, 8, "R1 last entry qword");
    // R2 dword fields
    do_wr(0, 16'h30, 4, 64'hFFFF_0000_1111_2222, "R2 alo");
    do_wr(0, 16'h34, 4, 64'h3333_4444, "R2 ahi");
    do_wr(0, 16'h38, 4, 64'h5555_6666, "R2 data");
    do_rd(0, 16'h30, 4, "R2 read alo");
    do_rd(0, 16'h34, 4, "R2 read ahi");
    do_rd(0, 16'h38, 4, "R2 read data");
    chk(ent_addr[3*64 +: 64] == 64'h3333_4444_1111_2222, "R12 entry addr out",
        ent_addr[3*64 +: 64], 64'h3333_4444_1111_2222);
    // R3 qword packing
    do_wr(0, 16'h40, 8, 64'hAAAA_BBBB_CCCC_DDDD, "R3 qword addr");
    do_rd(0, 16'h40, 4, "R3 low half");
    do_rd(0, 16'h44, 4, "R3 high half");
    do_wr(0, 16'h48, 8, 64'hFFFF_FFFE_1234_5678, "R3 R10 qword ctl+data");
    do_rd(0, 16'h48, 8, "R3 read ctl+data");
    // R4 only mask bit kept
    do_wr(0, 16'h4C, 4, 64'hFFFF_FFFF, "R4 ctl all ones");
    do_rd(0, 16'h4C, 4, "R4 ctl reads 1");
    // R10 / R11 change-only pulses
    do_wr(0, 16'h5C, 4, 64'h0, "R10 unmask v5");
    do_wr(0, 16'h5C, 4, 64'h0, "R10 repeat no pulse");
    do_wr(0, 16'h30, 4, 64'h1111_2222, "R11 same value no pulse");
    do_wr(0, 16'h38, 4, 64'h5555_6667, "R11 data change");
    // R5 out of range
    do_wr(0, N * 16, 4, 64'h0, "R5 write past end");
    do_wr(0, N * 16 + 8, 8, 64'h1, "R5 qword past end");
    do_rd(0, N * 16 + 12, 4, "R5 read past end");
    // R6 misaligned / bad size
    do_wr(0, 16'h32, 4, 64'hDEAD, "R6 misaligned dword");
    do_wr(0, 16'h34, 8, 64'hDEAD, "R6 misaligned qword");
    do_wr(0, 16'h30, 2, 64'hDEAD, "R6 size 2");
    do_rd(0, 16'h30, 2, "R6 read size 2");
    chk_ents("R6 R5 entries intact");
    // R7 R9 pending layout and priority
    do_pend(N'(1) << 65 | N'(1) << 63 | N'(1) << 2, N'(1) << 2, "R9 set wins");
    do_rd(1, 8, 4, "R7 second qword low");
    do_rd(1, 12, 4, "R7 second qword high");
    do_rd(1, 4, 4, "R7 first qword high");
    do_rd(1, 0, 8, "R7 first qword");
    do_rd(1, 16, 8, "R7 qword past array");
    do_pend('0, N'(1) << 63, "R9 clear");
    // R8 pending writes dropped
    do_wr(1, 8, 8, '1, "R8 pba write");
    do_wr(1, 0, 4, '1, "R8 pba dword write");
    chk(pend_out == m_pend, "R8 pending unchanged", 64'(pend_out), 64'(m_pend));
    do_rd(1, 8, 8, "R8 R7 read after write");
    // random mix
    for (int k = 0; k < 1500; k++) begin
      int kind = $urandom_range(0, 5);
      int sz;
      int off;
      case ($urandom_range(0, 7))
        0, 1, 2: sz = 4;
        3, 4, 5: sz = 8;
        6: sz = 2;
        default: sz = 16;
      endcase
      off = $urandom_range(0, N * 16 + 48);
      if ($urandom_range(0, 9) != 0) off = off & ~(sz == 8 ? 7 : 3);
      case (kind)
        0, 1: do_wr(0, off, sz, {$urandom, $urandom}, "R2 R3 R5 R6 rand write");
        2:    do_rd(0, off, sz, "R2 R3 R4 R5 R6 rand read");
        3:    do_rd(1, $urandom_range(0, 23) & ~(sz == 8 ? 7 : 3), sz, "R7 rand pba read");
        4: begin
          logic [N-1:0] s = '0, c = '0;
          for (int b = 0; b < N; b++) begin
            s[b] = ($urandom_range(0, 7) == 0);
            c[b] = ($urandom_range(0, 5) == 0);
          end
          do_pend(s, c, "R9 rand pending");
        end
        default: do_wr(1, $urandom_range(0, 15) & ~3, 4, {$urandom, $urandom}, "R8 rand pba write");
      endcase
    end
    chk_ents("R12 final entries");
    chk(pend_out == m_pend, "R9 final pending", 64'(pend_out), 64'(m_pend));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule